// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers 32 level-sensitive interrupt inputs and drives 15 output lines. Each input carries an enable bit and a 4-bit route code. A code of zero leaves the input unconnected. A non-zero code names the output line that the input drives. An output line stays high while at least one enabled input routed to it is high, and it falls once no such input remains.

Software reaches the block through a simple 32-bit register bus. The bus has a request strobe, a write flag, a byte address and write data. Read data is registered. Each input is synchronised before it reaches the status register and the output logic. Software reads the raw synchronised levels from the status register and combines them with the enable register to find the pending set. Route codes are packed eight to a word, and the packing runs in reverse order across the four route words.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the enable register and every route field read as zero, and every output line is low.
- R2: An input change reaches the status register and the output lines after exactly two rising clock edges, through a two-flop synchroniser.
- R3: A read at offset 0x04 returns the synchronised level of every input (bit n = input n), whatever its enable bit and route. Writes to offset 0x04 change no state.
- R4: Offset 0x00 is the enable register. Bit n enables input n, and a write replaces all 32 bits, which read back unchanged.
- R5: The route words sit at offsets 0x08, 0x0C, 0x10 and 0x14. Inputs 24..31 are in word 0x08, 16..23 in 0x0C, 8..15 in 0x10 and 0..7 in 0x14. Input n uses bits [4*(n mod 8)+3 : 4*(n mod 8)] of its word.
- R6: Route code 0 disconnects an input. Code c in 1..15 drives output line c-1.
- R7: Output k is high exactly when some input n has a synchronised level of 1, enable bit n set and route code k+1. The output stays high while any such input remains high, and a change to the enable or route registers takes effect in the cycle after the write.
- R8: Reads of any offset other than 0x00..0x14 return zero, and writes to such offsets change no state. Address bits [1:0] are ignored.
- R9: rdata_o takes the addressed value on the clock edge that accepts a read (req_i high, we_i low) and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Level interrupt inputs |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write flag |
| addr_i | input | 8 | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Registered bus read data |
| irq_o | output | 15 | Routed interrupt output lines |

## Verification
The bench targets the reversed route packing. It drives inputs 3 and 31 and checks which output line rises; a design with the packing in forward order would light the wrong line or none. It holds an input with route code 0 high, and a design that decoded code 0 as line 0 would raise output 0. It routes two inputs to one line and drops them one at a time, which exposes an OR tree that keeps only one term. It also counts the synchroniser latency edge by edge and writes to the status and unmapped offsets. A design with one stage too few or too many, or one that let those writes reach the enable register, would show it on irq_o or on a later read.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_IN      = 32;
  localparam int NUM_OUT     = 15;
  localparam int CODE_W      = 4;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int FIELDS_PER_WORD = DATA_W / CODE_W;
  localparam int NUM_ROUTE_WORDS = NUM_IN / FIELDS_PER_WORD;
  localparam int WORD_MASK   = 0;
  localparam int WORD_STATUS = 1;
  localparam int WORD_ROUTE0 = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_route_pkg::*;
#(
  parameter int N_IN   = NUM_IN,
  parameter int C_W    = CODE_W,
  parameter int D_W    = DATA_W,
  parameter int A_W    = ADDR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [A_W-1:0]            addr_i,
  input  logic [D_W-1:0]            wdata_i,
  input  logic [N_IN-1:0]           status_i,
  output logic [D_W-1:0]            rdata_o,
  output logic [N_IN-1:0]           mask_o,
  output logic [N_IN-1:0][C_W-1:0]  route_o
);
  localparam int FPW    = D_W / C_W;
  localparam int NWORDS = N_IN / FPW;
  localparam int WORD_W = A_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              wr_en, rd_en;
  logic [N_IN-1:0]   mask_q;
  logic [D_W-1:0]    rd_val, rdata_q;

  assign word_idx = addr_i[A_W-1:2];
  assign wr_en    = req_i & we_i;
  assign rd_en    = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (wr_en && word_idx == WORD_W'(WORD_MASK)) mask_q <= wdata_i[N_IN-1:0];
  end

  // group g (inputs g*FPW..) sits in the word counted from the top: reversed packing
  for (genvar g = 0; g < NWORDS; g++) begin : g_grp
    localparam logic [WORD_W-1:0] GRP_WORD = WORD_W'(WORD_ROUTE0 + NWORDS - 1 - g);
    logic [FPW-1:0][C_W-1:0] grp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grp_q <= '0;
      else if (wr_en && word_idx == GRP_WORD) grp_q <= wdata_i;
    end
    assign route_o[g*FPW +: FPW] = grp_q;
  end

  always_comb begin
    rd_val = '0;
    if (word_idx == WORD_W'(WORD_MASK))   rd_val[N_IN-1:0] = mask_q;
    if (word_idx == WORD_W'(WORD_STATUS)) rd_val[N_IN-1:0] = status_i;
    for (int g = 0; g < NWORDS; g++)
      if (word_idx == WORD_W'(WORD_ROUTE0 + NWORDS - 1 - g)) rd_val = route_o[g*FPW +: FPW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int N_IN  = NUM_IN,
  parameter int N_OUT = NUM_OUT,
  parameter int C_W   = CODE_W
) (
  input  logic [N_IN-1:0]          level_i,
  input  logic [N_IN-1:0]          mask_i,
  input  logic [N_IN-1:0][C_W-1:0] route_i,
  output logic [N_OUT-1:0]         irq_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [N_IN-1:0] hit;
    for (genvar n = 0; n < N_IN; n++) begin : g_in
      assign hit[n] = level_i[n] & mask_i[n] & (route_i[n] == C_W'(k + 1));
    end
    assign irq_o[k] = |hit;
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_OUT-1:0] irq_o
);
  logic [NUM_IN-1:0]             status_q;
  logic [NUM_IN-1:0]             mask_q;
  logic [NUM_IN-1:0][CODE_W-1:0] route_q;

  irq_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (status_q)
  );

  irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(status_q),
    .rdata_o (rdata_o),
    .mask_o  (mask_q),
    .route_o (route_q)
  );

  irq_route_matrix u_matrix (
    .level_i(status_q),
    .mask_i (mask_q),
    .route_i(route_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
  import irq_route_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IN-1:0]  irq_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_OUT-1:0] irq_o,
  input logic [NUM_IN-1:0]  mask_q,
  input logic [NUM_IN-1:0]  status_q
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  logic [1:0]        since_rst;
  logic [NUM_IN-1:0] irq_d1, irq_d2;

  assign word = addr_i[ADDR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0;
      irq_d1 <= '0;
      irq_d2 <= '0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      irq_d1 <= irq_i;
      irq_d2 <= irq_d1;
    end
  end

  // R2
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst >= 2'd2 |-> status_q == irq_d2);

  // R4
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && word == WORD_W'(WORD_MASK) |=> mask_q == $past(wdata_i));

  // R3
  status_write_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && word == WORD_W'(WORD_STATUS) |=> $stable(mask_q));

  // R3
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && word == WORD_W'(WORD_STATUS) |=> rdata_o == $past(status_q));

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && word > WORD_W'(WORD_ROUTE0 + NUM_ROUTE_WORDS - 1) |=> rdata_o == '0);

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R7
  no_source_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & mask_q) == '0 |-> irq_o == '0);
endmodule

bind irq_route_ctrl irq_route_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_i   (irq_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .mask_q  (mask_q),
  .status_q(status_q)
);

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [14:0] irq_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_req = "R1";

  // reference state
  logic [31:0] m_mask = '0;
  logic [3:0]  m_route [32];
  logic [31:0] m_s1 = '0, m_s2 = '0;
  logic [31:0] m_rdata = '0;

  always #2 clk = ~clk;

  irq_route_ctrl u_irq_route_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_out)
  );

  // route word at 0x08+4*w holds inputs (3-w)*8 .. (3-w)*8+7
  function automatic int grp_of(input logic [7:0] a);
    return 3 - (int'(a[7:2]) - 2);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    int w;
    v = '0;
    w = int'(a[7:2]);
    if (w == 0) v = m_mask;
    else if (w == 1) v = m_s2;
    else if (w >= 2 && w <= 5)
      for (int j = 0; j < 8; j++) v[4*j +: 4] = m_route[grp_of(a)*8 + j];
    return v;
  endfunction

  function automatic logic [14:0] m_out();
    logic [14:0] o;
    o = '0;
    for (int n = 0; n < 32; n++)
      if (m_s2[n] && m_mask[n] && m_route[n] != 4'd0) o[int'(m_route[n]) - 1] = 1'b1;
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_s1 = '0; m_s2 = '0; m_rdata = '0;
      for (int n = 0; n < 32; n++) m_route[n] = '0;
    end else begin
      if (req && !we) m_rdata = m_read(addr);
      if (req && we) begin
        if (addr[7:2] == 6'd0) m_mask = wdata;
        else if (addr[7:2] >= 6'd2 && addr[7:2] <= 6'd5)
          for (int j = 0; j < 8; j++) m_route[grp_of(addr)*8 + j] = wdata[4*j +: 4];
      end
      m_s2 = m_s1;
      m_s1 = irq;
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, {17'd0, irq_out}, {17'd0, m_out()});
      check("R9", rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1", {17'd0, irq_out}, '0);
    rd(8'h00, v); check("R1", v, '0);
    for (int w = 2; w < 6; w++) begin
      rd(8'(w * 4), v); check("R1", v, '0);
    end

    cur_req = "R4";
    wr(8'h00, 32'hA5A5_0F0F);
    rd(8'h00, v); check("R4", v, 32'hA5A5_0F0F);
    rd(8'h03, v); check("R8", v, 32'hA5A5_0F0F);

    cur_req = "R5";
    wr(8'h14, 32'h8765_4321);
    rd(8'h14, v); check("R5", v, 32'h8765_4321);
    rd(8'h08, v); check("R5", v, 32'h0);
    wr(8'h08, 32'hF000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    irq = 32'h1 << 3;
    idle(3); check("R5", {17'd0, irq_out}, 32'h1 << 3);
    irq = 32'h1 << 31;
    idle(3); check("R5", {17'd0, irq_out}, 32'h1 << 14);

    cur_req = "R6";
    irq = 32'h1 << 24;
    idle(3); check("R6", {17'd0, irq_out}, '0);
    irq = (32'h1 << 7) | (32'h1 << 2);
    idle(3); check("R6", {17'd0, irq_out}, (32'h1 << 7) | (32'h1 << 2));
    irq = '0;
    idle(3);

    cur_req = "R2";
    @(negedge clk); irq = 32'h1;
    @(negedge clk); check("R2", {17'd0, irq_out}, '0);
    @(negedge clk); check("R2", {17'd0, irq_out}, 32'h1);
    irq = '0;
    @(negedge clk); check("R2", {17'd0, irq_out}, 32'h1);
    @(negedge clk); check("R7", {17'd0, irq_out}, '0);

    cur_req = "R7";
    wr(8'h10, 32'h0000_0011);
    irq = (32'h1 << 8) | (32'h1 << 9);
    idle(3); check("R7", {17'd0, irq_out}, 32'h1);
    irq = 32'h1 << 9;
    idle(3); check("R7", {17'd0, irq_out}, 32'h1);
    wr(8'h00, 32'hFFFF_FDFF);
    check("R7", {17'd0, irq_out}, '0);
    irq = '0;
    idle(3);

    cur_req = "R3";
    wr(8'h00, 32'h0000_1234);
    irq = 32'hDEAD_BEEF;
    idle(3);
    rd(8'h04, v); check("R3", v, 32'hDEAD_BEEF);
    wr(8'h04, 32'h0);
    rd(8'h00, v); check("R3", v, 32'h0000_1234);
    rd(8'h04, v); check("R3", v, 32'hDEAD_BEEF);

    cur_req = "R8";
    rd(8'h18, v); check("R8", v, '0);
    rd(8'h80, v); check("R8", v, '0);
    rd(8'hFC, v); check("R8", v, '0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R8", v, 32'h0000_1234);
    rd(8'h0C, v); check("R8", v, 32'h0);

    rd(8'h14, v);
    idle(2); check("R9", rdata, 32'h8765_4321);

    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      irq = $urandom();
      if (($urandom() & 32'h7) == 0) begin
        req = 1'b1; we = $urandom() & 1; addr = 8'($urandom() & 32'h1F);
        wdata = $urandom();
      end else begin
        req = 1'b0; we = 1'b0;
      end
    end
    @(negedge clk); req = 1'b0; we = 1'b0;
    idle(3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule